// File: doc/BRIEF.md
# Centre-Aligned PWM Generator with Buffered Duty

The block runs a 16-bit counter that climbs from zero to a programmable peak value and then falls back to zero, over and over, so the count traces a triangle. One PWM output is driven high while the count is below the active duty threshold. The resulting pulse is centred on each valley of the triangle. The block raises a one-clock pulse when the count sits at the peak and another when it sits at the valley. The peak pulse is meant to be shared with the line that normally signals counter overflow.

Software loads a new peak value and a new duty value through a simple write port, and both go into holding buffers first. The peak buffer moves into the active peak register only at a valley. The point at which the duty buffer moves into the active threshold depends on the selected mode:

- **Symmetric mode:** the transfer happens only at a valley, so both halves of every PWM cycle use the same threshold.
- **Asymmetric mode:** the transfer happens at every peak and at every valley. The rising half and the falling half of a cycle can then use different thresholds.

Top module: `tri_pwm_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block resets: the count becomes 0 and counts up next, the active and buffered peak become DEF_CREST, and the active and buffered duty become 0. In the first cycle after reset, cnt_o is 0, valley_o is 1, peak_o is 0 and pwm_o is 0.
- R2: The count steps by one on every clock. It goes up from 0 until it equals the active peak value, then goes down until it reaches 0, then goes up again. Neither endpoint is held for two cycles, so one triangle lasts 2 × peak clocks.
- R3: peak_o is 1 in exactly the cycles where the count equals the active peak value. valley_o is 1 in exactly the cycles where the count is 0. Each of these pulses is one clock wide.
- R4: A write is taken when wr_en is 1 at a rising edge. With wr_sel = 0, wr_data goes to the peak buffer, and a value of 0 is stored as 1. With wr_sel = 1, wr_data goes to the duty buffer.
- R5: The peak buffer is copied into the active peak value only at the edge that ends a valley cycle. The new peak therefore takes effect from the next rising ramp.
- R6: When mode_asym is 0, the duty buffer is copied into the active duty threshold only at the edge that ends a valley cycle. A value written at a peak is not used on the falling ramp that follows it; it is first used on the next rising ramp.
- R7: When mode_asym is 1, the duty buffer is copied at the edge that ends a valley cycle and also at the edge that ends a peak cycle. A value written at a peak therefore drives the next rising ramp, and a value written at a valley drives the next falling ramp.
- R8: pwm_o is 1 exactly when the count is below the active duty threshold. A threshold of 0 holds the output low for the whole cycle. A threshold greater than the active peak holds it high for the whole cycle.
- R9: A write, or a change of mode_asym, never changes the count sequence or the event pulses in the same cycle; only the buffered transfers at peak or valley do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_asym | input | 1 | 0 = symmetric (duty transfer at valley only), 1 = asymmetric (duty transfer at peak and at valley) |
| wr_en | input | 1 | Write strobe for the buffers |
| wr_sel | input | 1 | Buffer select: 0 = peak, 1 = duty |
| wr_data | input | 16 | Value written to the selected buffer |
| cnt_o | output | 16 | Current count |
| pwm_o | output | 1 | PWM level |
| peak_o | output | 1 | One-clock pulse while the count equals the peak value |
| valley_o | output | 1 | One-clock pulse while the count is 0 |

## Verification
The assertions take for granted that the active peak value is never zero. The block guarantees this itself by turning a written 0 into 1, so the peak and valley events can never coincide. They also take for granted that a write is a single-cycle strobe sampled at the clock edge, with no handshake.

The stimulus drives every input just after a rising edge or at a falling edge, so each input is stable at the edge where it is sampled. It times duty writes to land exactly in peak or valley cycles. This exercises the corner where a write and a transfer happen at the same edge, where the transfer must still take the old buffer contents.

// File: rtl/tri_pwm_pkg.sv
// Shared definitions for the centre-aligned PWM generator.
// Assumes a single clock domain and a synchronous active-low reset.
package tri_pwm_pkg;

    // Which holding buffer a write targets.
    typedef enum logic {
        SEL_PEAK = 1'b0,
        SEL_DUTY = 1'b1
    } wsel_e;

    // A zero peak would merge the two events; map it to the smallest legal peak.
    function automatic logic [15:0] peak_floor(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

endpackage

// File: rtl/tri_pwm_counter.sv
// Up/down triangle counter.
// Counts up from 0 to peak_val, then down to 0, and repeats.
// Neither endpoint is visited twice in a row.
// Raises the peak and valley event flags from the current count.
// Assumes peak_val is never 0 and changes only at a valley.
module tri_pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] peak_val,
    output logic [W-1:0] cnt,
    output logic         peak_ev,
    output logic         valley_ev
);

    logic going_up;

    // Event flags decoded from the current count.
    always_comb begin
        peak_ev   = (cnt == peak_val);
        valley_ev = (cnt == '0);
    end

    // Advance the count and turn around at each endpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            going_up <= 1'b1;
        end else if (valley_ev) begin
            cnt      <= W'(1);
            going_up <= 1'b1;
        end else if (going_up && peak_ev) begin
            cnt      <= cnt - W'(1);
            going_up <= 1'b0;
        end else if (going_up) begin
            cnt      <= cnt + W'(1);
        end else begin
            cnt      <= cnt - W'(1);
        end
    end

    // R2: the count never exceeds the active peak.
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= peak_val);

    // R2: on a rising ramp between the endpoints, the count moves up by exactly one.
    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (going_up && !peak_ev && !valley_ev) |=> (cnt == W'($past(cnt) + W'(1))));

    // R3: a peak pulse lasts a single clock.
    p_peak_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        peak_ev |=> !peak_ev);

    // R3: a valley pulse lasts a single clock.
    p_valley_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valley_ev |=> !valley_ev);

endmodule

// File: rtl/tri_pwm_regs.sv
// Holding buffers and active registers for the peak value and the duty threshold.
// The peak buffer moves to the active peak at a valley.
// The duty buffer moves at a valley, and also at a peak when asymmetric mode is selected.
// A write in the same cycle as a transfer lands in the buffer;
// the transfer takes the buffer's previous contents.
module tri_pwm_regs
    import tri_pwm_pkg::*;
#(
    parameter int          W         = 16,
    parameter logic [15:0] DEF_CREST = 16'd8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_asym,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         peak_ev,
    input  logic         valley_ev,
    output logic [W-1:0] peak_act,
    output logic [W-1:0] duty_act
);

    localparam logic [W-1:0] PEAK_RST = W'(peak_floor(DEF_CREST));

    logic [W-1:0] peak_buf;
    logic [W-1:0] duty_buf;
    logic         duty_xfer;

    // Duty transfer instant: every valley, plus every peak in asymmetric mode.
    always_comb duty_xfer = valley_ev || (peak_ev && mode_asym);

    // Capture writes from the register port into the holding buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_buf <= PEAK_RST;
            duty_buf <= '0;
        end else if (wr_en) begin
            if (wsel_e'(wr_sel) == SEL_PEAK)
                peak_buf <= W'(peak_floor(16'(wr_data)));
            else
                duty_buf <= wr_data;
        end
    end

    // Move the buffers into the active registers at the transfer instants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_act <= PEAK_RST;
            duty_act <= '0;
        end else begin
            if (valley_ev) peak_act <= peak_buf;
            if (duty_xfer) duty_act <= duty_buf;
        end
    end

    // R5: the active peak changes only after a valley cycle.
    p_peak_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valley_ev |=> $stable(peak_act));

    // R6/R7: the active duty changes only after a permitted transfer cycle.
    p_duty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valley_ev && !(peak_ev && mode_asym)) |=> $stable(duty_act));

    // R4: the active peak is never zero.
    p_peak_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        peak_act != '0);

endmodule

// File: rtl/tri_pwm_compare.sv
// Output comparator: drives the PWM level high while the count is below the active threshold.
// Assumes the count and the threshold come from registers in the same clock domain.
module tri_pwm_compare #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty_act,
    output logic         pwm
);

    // Level compare against the active threshold.
    always_comb pwm = (cnt < duty_act);

endmodule

// File: rtl/tri_pwm_gen.sv
// Centre-aligned PWM generator, top level.
// Wires together the triangle counter, the buffered peak and duty registers, and the output comparator.
// The peak pulse is meant to share the overflow interrupt line.
// Assumes a single clock and a synchronous active-low reset.
module tri_pwm_gen #(
    parameter int          W         = 16,
    parameter logic [15:0] DEF_CREST = 16'd8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_asym,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_o,
    output logic         pwm_o,
    output logic         peak_o,
    output logic         valley_o
);

    logic [W-1:0] peak_act;
    logic [W-1:0] duty_act;
    logic [W-1:0] cnt;
    logic         peak_ev;
    logic         valley_ev;

    tri_pwm_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .peak_val  (peak_act),
        .cnt       (cnt),
        .peak_ev   (peak_ev),
        .valley_ev (valley_ev)
    );

    tri_pwm_regs #(.W(W), .DEF_CREST(DEF_CREST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_asym (mode_asym),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .peak_ev   (peak_ev),
        .valley_ev (valley_ev),
        .peak_act  (peak_act),
        .duty_act  (duty_act)
    );

    tri_pwm_compare #(.W(W)) u_cmp (
        .cnt      (cnt),
        .duty_act (duty_act),
        .pwm      (pwm)
    );

    logic pwm;

    // Drive the outputs from the internal nets.
    always_comb begin
        cnt_o    = cnt;
        pwm_o    = pwm;
        peak_o   = peak_ev;
        valley_o = valley_ev;
    end

    // R3: the peak and valley events never coincide.
    p_events_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(peak_ev && valley_ev));

    // R8: a threshold above the peak keeps the output high.
    p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act > peak_act) |-> pwm);

    // R8: a zero threshold keeps the output low.
    p_zero_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm);

endmodule

// File: tb/tb_tri_pwm_gen.sv
// Self-checking bench.
// A behavioural reference model advances on every rising edge, and the outputs are compared on every falling edge.
module tb_tri_pwm_gen;

    localparam int DEF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_asym = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] cnt_o;
    logic        pwm_o;
    logic        peak_o;
    logic        valley_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit model_ok = 0;
    bit done = 0;

    // Reference model state.
    int  m_cnt, m_peak, m_duty, m_pbuf, m_dbuf;
    bit  m_up;

    tri_pwm_gen #(.W(16), .DEF_CREST(16'(DEF))) dut (
        .clk(clk), .rst_n(rst_n), .mode_asym(mode_asym), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cnt_o(cnt_o), .pwm_o(pwm_o),
        .peak_o(peak_o), .valley_o(valley_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Advance the model at each rising edge, using the inputs sampled at that edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_peak = DEF; m_duty = 0; m_pbuf = DEF; m_dbuf = 0;
            model_ok = 1;
        end else if (model_ok) begin
            bit pk, vl;
            pk = (m_cnt == m_peak);
            vl = (m_cnt == 0);
            if (vl || (pk && mode_asym)) m_duty = m_dbuf;
            if (vl) m_peak = m_pbuf;
            if (wr_en) begin
                if (wr_sel == 1'b0) m_pbuf = (wr_data == 0) ? 1 : int'(wr_data);
                else m_dbuf = int'(wr_data);
            end
            if (vl) begin m_cnt = 1; m_up = 1; end
            else if (m_up && pk) begin m_cnt = m_cnt - 1; m_up = 0; end
            else if (m_up) m_cnt = m_cnt + 1;
            else m_cnt = m_cnt - 1;
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (model_ok && rst_n) begin
            check(int'(cnt_o) == m_cnt, "R2 count", int'(cnt_o), m_cnt);
            check(peak_o == (m_cnt == m_peak), "R3 peak pulse", peak_o, m_cnt == m_peak);
            check(valley_o == (m_cnt == 0), "R3 valley pulse", valley_o, m_cnt == 0);
            check(pwm_o == (m_cnt < m_duty), "R8 pwm level", pwm_o, m_cnt < m_duty);
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic write_now(input bit sel, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr(input bit sel, input int val);
        @(posedge clk); #1;
        write_now(sel, val);
    endtask

    // Wait for a falling edge that shows the given count while moving in the given direction.
    task automatic wait_cnt(input int v, input bit up);
        int prev;
        @(negedge clk);
        prev = int'(cnt_o);
        forever begin
            @(negedge clk);
            if (int'(cnt_o) == v && ((int'(cnt_o) > prev) == up)) break;
            prev = int'(cnt_o);
        end
    endtask

    task automatic wait_peak();
        do @(negedge clk); while (!peak_o);
    endtask

    task automatic wait_valley();
        do @(negedge clk); while (!valley_o);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state seen in the first cycle after release
        check(cnt_o == 0, "R1 count after reset", int'(cnt_o), 0);
        check(valley_o == 1'b1, "R1 valley after reset", valley_o, 1);
        check(peak_o == 1'b0, "R1 peak after reset", peak_o, 0);
        check(pwm_o == 1'b0, "R1 pwm after reset", pwm_o, 0);
        // R2: the peak is reached DEF clocks after the valley
        wait_peak();
        check(int'(cnt_o) == DEF, "R2 default peak", int'(cnt_o), DEF);

        // R8: a duty of 3 in symmetric mode
        wr(1'b1, 3);
        repeat (40) @(posedge clk);

        // R4/R5: a written peak of 0 becomes 1 after the next valley
        wr(1'b0, 0);
        wait_valley();
        wait_peak();
        check(int'(cnt_o) == 1, "R4 zero peak floored", int'(cnt_o), 1);
        repeat (6) @(posedge clk);
        wr(1'b0, 10);
        wait_valley();
        wait_peak();
        check(int'(cnt_o) == 10, "R5 new peak applied", int'(cnt_o), 10);

        // R6: a duty written at the peak waits for the next valley
        wait_peak();
        write_now(1'b1, 6);
        wait_cnt(4, 1'b0);
        check(pwm_o == 1'b0, "R6 old duty on falling ramp", pwm_o, 0);
        wait_cnt(4, 1'b1);
        check(pwm_o == 1'b1, "R6 new duty on rising ramp", pwm_o, 1);

        // R7: in asymmetric mode the rising and falling ramps use different thresholds
        @(posedge clk); #1 mode_asym = 1'b1;
        wait_peak();
        write_now(1'b1, 2);
        wait_valley();
        write_now(1'b1, 7);
        wait_cnt(5, 1'b1);
        check(pwm_o == 1'b0, "R7 rising ramp threshold", pwm_o, 0);
        wait_cnt(5, 1'b0);
        check(pwm_o == 1'b1, "R7 falling ramp threshold", pwm_o, 1);

        // R8: a threshold above the peak holds the output high for a whole triangle
        @(posedge clk); #1 mode_asym = 1'b0;
        wr(1'b1, 20);
        wait_valley();
        wait_valley();
        begin
            int highs = 0;
            for (int i = 0; i < 20; i++) begin
                if (pwm_o) highs++;
                @(negedge clk);
            end
            check(highs == 20, "R8 full duty", highs, 20);
        end

        // R9: a write away from the endpoints leaves the count sequence untouched
        wait_cnt(3, 1'b1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd4;
        mode_asym = 1'b1;
        @(negedge clk);
        check(int'(cnt_o) == 4, "R9 count unaffected by write", int'(cnt_o), 4);
        wr_en = 1'b0;
        mode_asym = 1'b0;
        repeat (60) @(posedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule